// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block derives every digital control waveform that a two-phase linear CCD line sensor needs from one fast system clock. Each line starts with a parallel charge move from the photodiodes into the readout register: transfer gate up, then photo gate up and held, then photo gate down, then transfer gate down. During this move the horizontal phases stay frozen. A serial readout of every register stage follows. In it, phase 1 and phase 2 toggle in opposition, a reset-gate pulse opens each pixel period, and a one-cycle strobe marks the moment a charge packet reaches the output node. An antiblooming drain pulse begins as the transfer gate closes. Its length sets the exposure, because integration runs from the end of that pulse to the next transfer.

Software supplies the element count, the transfer-gate lead, the photo-gate width, the transfer-gate tail and the drain width, all as counts of system-clock cycles. Any value below its hardware minimum is raised to that minimum. A line starts on `line_start` only when `busy` is low, and the configuration is captured in that same cycle. The readout strobe has no ready input. The sensor cannot be stalled, so whatever follows must accept each strobe in the cycle it appears.

Top module: `ccdline_timer`

## Requirements
- R1: While reset is held and right after it, `h_phi1`=1 and `h_phi2`=0. `reset_gate`, `xfer_gate`, `photo_gate`, `ab_gate`, `busy` and `pix_valid` are 0, and `pix_slot` and `pix_tag` are 0.
- R2: When `line_start` is high at a clock edge and `busy` is low, `xfer_gate` is high from the next cycle on. For the whole transfer, `h_phi1` stays 1 and `h_phi2` stays 0.
- R3: `xfer_gate` is high for max(lead,1) cycles before `photo_gate` rises. `photo_gate` then stays high for max(pgw,25) cycles. `xfer_gate` stays high for max(tail,2) more cycles after `photo_gate` falls.
- R4: In the first cycle after `xfer_gate` falls, readout begins. Each register stage takes one period of 2·PIX_HALF cycles: `h_phi1` is high for the first PIX_HALF cycles and low for the rest, and `h_phi2` is always its complement.
- R5: `reset_gate` is high only in the first cycle of each readout period, so it is low in the cycle before every falling edge of `h_phi1`.
- R6: `pix_valid` is high for exactly one cycle per stage, the cycle in which `h_phi1` falls. `pix_slot` holds the zero-based stage index for the whole period.
- R7: With element count n=max(cfg,1), the stage order is: 3 isolation, 10 dark, 2 transition, n active, 2 transition, 10 dark (present only when n>512), then 3 isolation. `pix_tag` encodes 1 isolation, 2 dark, 3 transition, 4 active, and 0 outside readout.
- R8: `ab_gate` rises in the cycle readout begins, which is at least two cycles after `photo_gate` fell. It stays high for max(abw,188) cycles and then stays low until the next line.
- R9: `busy` is high from the cycle after acceptance until both readout and the drain pulse have ended. A `line_start` while busy is ignored, and configuration changes after acceptance have no effect on the running line.
- R10: After the last stage, the horizontal phases return to the frozen state (`h_phi1`=1, `h_phi2`=0), and the block stays idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Request a new line; taken when not busy |
| cfg_elements | input | CFG_W | Active element count |
| cfg_tg_lead | input | CFG_W | Transfer-gate cycles before photo gate rises |
| cfg_pg_width | input | CFG_W | Photo-gate high cycles |
| cfg_tg_tail | input | CFG_W | Transfer-gate cycles after photo gate falls |
| cfg_ab_width | input | CFG_W | Drain pulse cycles (exposure control) |
| busy | output | 1 | Line in progress |
| h_phi1 | output | 1 | Horizontal phase 1 |
| h_phi2 | output | 1 | Horizontal phase 2 |
| reset_gate | output | 1 | Output-node reset pulse |
| xfer_gate | output | 1 | Transfer gate |
| photo_gate | output | 1 | Photo gate |
| ab_gate | output | 1 | Antiblooming / exposure drain gate |
| pix_valid | output | 1 | One-cycle strobe per readout stage |
| pix_slot | output | CFG_W+1 | Stage index within the line |
| pix_tag | output | 3 | Stage class code |

## Verification
Two events can share a cycle here: the end of a line (the last readout period, or the last drain cycle) and the acceptance of the next start. To provoke this, the bench holds `line_start` high across two lines and changes the configuration right after the first is taken. It also sizes the second line so that its drain pulse and its readout end on the same cycle. A behavioural model keeps its own cycle count from each acceptance and compares all outputs on every clock. This shows whether the next transfer begins exactly one cycle after `busy` drops, and whether it uses the values present at acceptance.

// File: rtl/ccdline_pkg.sv
package ccdline_pkg;
  localparam int ISO_N          = 3;
  localparam int DARK_N         = 10;
  localparam int TRAN_N         = 2;
  localparam int TAIL_DARK_FROM = 512;
  localparam int EDGE_SLOTS     = 2 * (ISO_N + TRAN_N) + DARK_N;

  typedef enum logic [2:0] {
    TAG_NONE   = 3'd0,
    TAG_ISO    = 3'd1,
    TAG_DARK   = 3'd2,
    TAG_TRANS  = 3'd3,
    TAG_ACTIVE = 3'd4
  } slot_tag_e;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_LEAD = 2'd1,
    XS_HOLD = 2'd2,
    XS_TAIL = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/ccdline_xfer.sv
module ccdline_xfer import ccdline_pkg::*; #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CFG_W-1:0] lead,
  input  logic [CFG_W-1:0] hold,
  input  logic [CFG_W-1:0] tail,
  output logic             tg,
  output logic             pg,
  output logic             done
);
  xfer_state_e      st;
  logic [CFG_W-1:0] cnt;

  assign done = (st == XS_TAIL) && (cnt == tail - 1'b1);
  assign tg   = (st != XS_IDLE);
  assign pg   = (st == XS_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= XS_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        XS_IDLE: if (go) begin st <= XS_LEAD; cnt <= '0; end
        XS_LEAD: if (cnt == lead - 1'b1) begin st <= XS_HOLD; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        XS_HOLD: if (cnt == hold - 1'b1) begin st <= XS_TAIL; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        default: if (done) begin st <= XS_IDLE; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
      endcase
    end
  end

  // R3: photo gate only rises under an already-open transfer gate
  assert_pg_after_tg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg) |-> $past(tg));
  // R3: transfer gate closes only after photo gate has been low a cycle
  assert_tg_after_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tg) |-> (!pg && !$past(pg)));
endmodule

// File: rtl/ccdline_hclk.sv
module ccdline_hclk #(
  parameter int PIX_HALF = 2,
  parameter int SLOT_W   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [SLOT_W-1:0] last_slot,
  output logic              phi1,
  output logic              phi2,
  output logic              rg,
  output logic              strobe,
  output logic [SLOT_W-1:0] slot,
  output logic              run
);
  localparam int PH_W = $clog2(2 * PIX_HALF);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * PIX_HALF - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(PIX_HALF);

  logic [PH_W-1:0]   ph;
  logic [SLOT_W-1:0] idx;

  assign phi1   = !run || (ph < PH_FALL);
  assign phi2   = !phi1;
  assign rg     = run && (ph == '0);
  assign strobe = run && (ph == PH_FALL);
  assign slot   = run ? idx : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      ph  <= '0;
      idx <= '0;
    end else if (!run) begin
      if (go) begin
        run <= 1'b1;
        ph  <= '0;
        idx <= '0;
      end
    end else if (ph == PH_LAST) begin
      ph <= '0;
      if (idx == last_slot) run <= 1'b0;
      else                  idx <= idx + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // R6: the stage strobe lands on a phase-1 falling edge
  assert_strobe_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (!phi1 && $past(phi1)));
endmodule

// File: rtl/ccdline_slotmap.sv
module ccdline_slotmap import ccdline_pkg::*; #(
  parameter int CFG_W  = 16,
  parameter int SLOT_W = 17
) (
  input  logic              run,
  input  logic              tail_dark,
  input  logic [CFG_W-1:0]  n,
  input  logic [SLOT_W-1:0] slot,
  output slot_tag_e         tag
);
  logic [SLOT_W-1:0] b_act, b_tr2, b_dk2;

  always_comb begin
    b_act = SLOT_W'(n) + SLOT_W'(ISO_N + DARK_N + TRAN_N);
    b_tr2 = b_act + SLOT_W'(TRAN_N);
    b_dk2 = b_tr2 + (tail_dark ? SLOT_W'(DARK_N) : '0);
    if (!run)                                     tag = TAG_NONE;
    else if (slot < SLOT_W'(ISO_N))               tag = TAG_ISO;
    else if (slot < SLOT_W'(ISO_N + DARK_N))      tag = TAG_DARK;
    else if (slot < SLOT_W'(ISO_N + DARK_N + TRAN_N)) tag = TAG_TRANS;
    else if (slot < b_act)                        tag = TAG_ACTIVE;
    else if (slot < b_tr2)                        tag = TAG_TRANS;
    else if (slot < b_dk2)                        tag = TAG_DARK;
    else                                          tag = TAG_ISO;
  end
endmodule

// File: rtl/ccdline_expo.sv
module ccdline_expo #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CFG_W-1:0] width,
  output logic             ab
);
  logic [CFG_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab  <= 1'b0;
      cnt <= '0;
    end else if (go) begin
      ab  <= 1'b1;
      cnt <= '0;
    end else if (ab) begin
      if (cnt == width - 1'b1) ab <= 1'b0;
      else                     cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ccdline_timer.sv
module ccdline_timer import ccdline_pkg::*; #(
  parameter int CFG_W    = 16,
  parameter int PIX_HALF = 2,
  parameter int LEAD_MIN = 1,
  parameter int PG_MIN   = 25,
  parameter int TAIL_MIN = 2,
  parameter int AB_MIN   = 188
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [CFG_W-1:0] cfg_elements,
  input  logic [CFG_W-1:0] cfg_tg_lead,
  input  logic [CFG_W-1:0] cfg_pg_width,
  input  logic [CFG_W-1:0] cfg_tg_tail,
  input  logic [CFG_W-1:0] cfg_ab_width,
  output logic             busy,
  output logic             h_phi1,
  output logic             h_phi2,
  output logic             reset_gate,
  output logic             xfer_gate,
  output logic             photo_gate,
  output logic             ab_gate,
  output logic             pix_valid,
  output logic [CFG_W:0]   pix_slot,
  output logic [2:0]       pix_tag
);
  localparam int SLOT_W = CFG_W + 1;

  function automatic logic [CFG_W-1:0] floor_at(input logic [CFG_W-1:0] v, input int m);
    return (v < CFG_W'(m)) ? CFG_W'(m) : v;
  endfunction

  logic [CFG_W-1:0]  n_q, lead_q, pg_q, tail_q, ab_q;
  logic              accept, xfer_done, run, tail_dark;
  logic [SLOT_W-1:0] last_slot;
  slot_tag_e         tag;

  assign busy      = xfer_gate || run || ab_gate;
  assign accept    = line_start && !busy;
  assign tail_dark = (n_q > CFG_W'(TAIL_DARK_FROM));
  assign last_slot = SLOT_W'(n_q) + SLOT_W'(EDGE_SLOTS - 1)
                   + (tail_dark ? SLOT_W'(DARK_N) : '0);
  assign pix_tag   = tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q    <= CFG_W'(1);
      lead_q <= CFG_W'(LEAD_MIN);
      pg_q   <= CFG_W'(PG_MIN);
      tail_q <= CFG_W'(TAIL_MIN);
      ab_q   <= CFG_W'(AB_MIN);
    end else if (accept) begin
      n_q    <= floor_at(cfg_elements, 1);
      lead_q <= floor_at(cfg_tg_lead, LEAD_MIN);
      pg_q   <= floor_at(cfg_pg_width, PG_MIN);
      tail_q <= floor_at(cfg_tg_tail, TAIL_MIN);
      ab_q   <= floor_at(cfg_ab_width, AB_MIN);
    end
  end

  ccdline_xfer #(.CFG_W(CFG_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .go(accept), .lead(lead_q), .hold(pg_q),
    .tail(tail_q), .tg(xfer_gate), .pg(photo_gate), .done(xfer_done));

  ccdline_hclk #(.PIX_HALF(PIX_HALF), .SLOT_W(SLOT_W)) u_hclk (
    .clk(clk), .rst_n(rst_n), .go(xfer_done), .last_slot(last_slot),
    .phi1(h_phi1), .phi2(h_phi2), .rg(reset_gate), .strobe(pix_valid),
    .slot(pix_slot), .run(run));

  ccdline_slotmap #(.CFG_W(CFG_W), .SLOT_W(SLOT_W)) u_map (
    .run(run), .tail_dark(tail_dark), .n(n_q), .slot(pix_slot), .tag(tag));

  ccdline_expo #(.CFG_W(CFG_W)) u_expo (
    .clk(clk), .rst_n(rst_n), .go(xfer_done), .width(ab_q), .ab(ab_gate));

  // R2: horizontal phases are frozen while the transfer gate is open
  assert_frozen_phases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> (h_phi1 && !h_phi2));
  // R5: reset gate already low in the cycle before phase 1 falls
  assert_rg_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_phi1) |-> !$past(reset_gate));
  // R8: drain opens at least two cycles after photo gate closed
  assert_ab_after_pg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ab_gate) |-> (!photo_gate && !$past(photo_gate) && !$past(photo_gate, 2)));
  // R9: a transfer only begins from an idle block
  assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_gate) |-> !$past(busy));
endmodule

// File: tb/ccdline_timer_tb.sv
`timescale 1ns/1ps
module ccdline_timer_tb;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [15:0] cfg_elements = '0, cfg_tg_lead = '0, cfg_pg_width = '0;
  logic [15:0] cfg_tg_tail = '0, cfg_ab_width = '0;
  logic        busy, h_phi1, h_phi2, reset_gate, xfer_gate, photo_gate;
  logic        ab_gate, pix_valid;
  logic [16:0] pix_slot;
  logic [2:0]  pix_tag;

  ccdline_timer u_dut (.*);

  always #2 clk = ~clk;

  int vec = 0, miss = 0, acc = 0;
  bit finished = 0;
  int t = -1, L = 0, P = 0, T = 0, ABW = 0, S = 0, R0 = 0, ENDC = 0;
  int tagq[$];

  function automatic int fl(int v, int m); return (v < m) ? m : v; endfunction

  task automatic cmp(string req, string nm, int act, int exp);
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0d", req, nm, act, exp, t);
    end
  endtask

  // behavioural reference: cycle count since acceptance
  always @(posedge clk) begin
    if (!rst_n) t = -1;
    else if ((t < 0 || t >= ENDC) && line_start) begin
      int n, td;
      n = fl(cfg_elements, 1); td = (n > 512) ? 10 : 0;
      L = fl(cfg_tg_lead, 1); P = fl(cfg_pg_width, 25);
      T = fl(cfg_tg_tail, 2); ABW = fl(cfg_ab_width, 188);
      tagq.delete();
      for (int i = 0; i < 3; i++)  tagq.push_back(1);
      for (int i = 0; i < 10; i++) tagq.push_back(2);
      for (int i = 0; i < 2; i++)  tagq.push_back(3);
      for (int i = 0; i < n; i++)  tagq.push_back(4);
      for (int i = 0; i < 2; i++)  tagq.push_back(3);
      for (int i = 0; i < td; i++) tagq.push_back(2);
      for (int i = 0; i < 3; i++)  tagq.push_back(1);
      S = tagq.size();
      R0 = L + P + T;
      ENDC = R0 + ((S * 2 * H > ABW) ? S * 2 * H : ABW);
      t = 0; acc++;
    end else if (t >= 0 && t < ENDC) t = t + 1;
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e1, erg, ev, es, etag, etg, epg, eab, eb, u, p;
      string ph;
      e1 = 1; erg = 0; ev = 0; es = 0; etag = 0; etg = 0; epg = 0; eab = 0; eb = 0;
      ph = "R10";
      if (t >= 0 && t < ENDC) begin
        eb = 1;
        if (t < R0) begin
          etg = 1; ph = "R2";
          epg = (t >= L && t < L + P) ? 1 : 0;
        end else begin
          u = t - R0;
          if (u < S * 2 * H) begin
            p = u % (2 * H);
            e1 = (p < H) ? 1 : 0; erg = (p == 0) ? 1 : 0; ev = (p == H) ? 1 : 0;
            es = u / (2 * H); etag = tagq[es]; ph = "R4";
          end
          eab = (t < R0 + ABW) ? 1 : 0;
        end
      end
      vec++;
      cmp(ph, "h_phi1", h_phi1, e1);
      cmp(ph, "h_phi2", h_phi2, 1 - e1);
      cmp("R3", "xfer_gate", xfer_gate, etg);
      cmp("R3", "photo_gate", photo_gate, epg);
      cmp("R5", "reset_gate", reset_gate, erg);
      cmp("R6", "pix_valid", pix_valid, ev);
      cmp("R6", "pix_slot", int'(pix_slot), es);
      cmp("R7", "pix_tag", pix_tag, etag);
      cmp("R8", "ab_gate", ab_gate, eab);
      cmp("R9", "busy", busy, eb);
    end
  end

  task automatic set_cfg(int n, int ld, int pw, int tl, int ab);
    cfg_elements = 16'(n); cfg_tg_lead = 16'(ld); cfg_pg_width = 16'(pw);
    cfg_tg_tail = 16'(tl); cfg_ab_width = 16'(ab);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (t >= 0 && t < ENDC) @(negedge clk);
  endtask

  task automatic pulse_start();
    line_start = 1'b1; @(negedge clk); line_start = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL R9 watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    // R1: reset state
    vec++;
    cmp("R1", "phi1/phi2", {h_phi1, h_phi2}, 2);
    cmp("R1", "gates", {reset_gate, xfer_gate, photo_gate, ab_gate}, 0);
    cmp("R1", "busy/valid", {busy, pix_valid}, 0);
    cmp("R1", "slot/tag", int'(pix_slot) + int'(pix_tag), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // line with drain longer than readout; start while busy ignored (R9)
    set_cfg(4, 3, 30, 4, 10);
    pulse_start();
    repeat (60) @(negedge clk);
    set_cfg(9, 7, 50, 9, 400);
    pulse_start();
    wait_idle();
    repeat (5) @(negedge clk);

    // all values below minimum: clamping (R3, R7, R8)
    set_cfg(0, 0, 0, 0, 300);
    pulse_start();
    wait_idle();
    repeat (3) @(negedge clk);

    // element count above 512: trailing dark group (R7)
    set_cfg(513, 2, 40, 3, 200);
    pulse_start();
    wait_idle();
    repeat (3) @(negedge clk);

    // back-to-back: start held; second line ends readout and drain together
    base = acc;
    set_cfg(512, 1, 25, 2, 300);
    line_start = 1'b1;
    while (acc < base + 1) @(negedge clk);
    set_cfg(50, 5, 26, 6, 280);
    while (acc < base + 2) @(negedge clk);
    line_start = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    summary();
  end
endmodule